// File: doc/BRIEF.md
# Atomic Set/Clear/Toggle Output Port

This block is a bank of general-purpose output pins whose levels live in one output register that sits behind a small memory-mapped register bus. Software can still replace the whole output word at once and read it back. Two further write-only registers let a writer change chosen pins with one bus write. Nothing has to be read first, so no read-modify-write sequence is needed. Pins that the write does not select keep their level.

The set/clear register splits the write word into two halves. The lower half raises pins and the upper half lowers them. The toggle register inverts every pin whose bit is written as 1. Because of this, code running in different contexts, such as an interrupt handler and a main loop, can each drive their own pins in the same port without a race. The bus has no wait states: every access completes in the cycle it is presented.

Top module: `gpio_atomic_port`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every pin is low and a read of the output register returns 0.
- R2: `bus_ready` is high in exactly the cycles in which `bus_sel` is high, so every access finishes in one cycle.
- R3: A write to the output register (byte address 0x0) replaces all 16 pins with `bus_wdata[15:0]`. Bits 31:16 of that write are ignored, and a read of this register returns the pins in bits 15:0 with bits 31:16 equal to zero.
- R4: A write to the set/clear register (address 0x4) with bit N = 1, for N in 0..15, drives pin N high.
- R5: A write to the set/clear register with bit N+16 = 1 drives pin N low, unless bit N of the same write is also 1.
- R6: If a set/clear write has both bit N and bit N+16 equal to 1, pin N goes high. Any pin whose two bits are both 0 keeps its level.
- R7: A write to the toggle register (address 0x8) inverts each pin N for which `bus_wdata[N]` is 1 and leaves every other pin unchanged. Bits 31:16 are ignored.
- R8: Reads of the set/clear register, the toggle register and the unmapped address 0xC return 0. A write to 0xC changes no pin.
- R9: A write takes effect on the pins at the clock edge that ends its bus cycle. A read in the same cycle as the write returns the old value, and a read in the next cycle returns the new value.
- R10: In a cycle where `bus_sel` or `bus_we` is low, no pin changes. `bus_rdata` is 0 whenever `bus_sel` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| bus_ready | output | 1 | Access complete |
| pin_out | output | 16 | Driven pin levels |

## Verification
Two operations can meet in a single cycle. The first is a set request and a clear request for the same pin inside one set/clear write. The bench causes this with words that set both halves for pins that are currently low and also for pins that are currently high, and it expects the set to win. The second is a read of the output register during the same cycle as a write to it. The bench reads and writes through one bus, and its reference model expects the value from before the edge in the write cycle and the new value in the cycle after.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    KIND_OUT    = 2'd0,
    KIND_SETCLR = 2'd1,
    KIND_TOGGLE = 2'd2,
    KIND_NONE   = 2'd3
  } reg_kind_e;

  // Next level of one pin for the selected register.
  // lo_bit: data / set / toggle bit, hi_bit: clear bit.
  function automatic logic pin_next(input logic cur, input reg_kind_e kind,
                                    input logic wr, input logic lo_bit,
                                    input logic hi_bit);
    logic nxt;
    nxt = cur;
    if (wr) begin
      case (kind)
        KIND_OUT:    nxt = lo_bit;
        KIND_SETCLR: nxt = lo_bit ? 1'b1 : (hi_bit ? 1'b0 : cur);
        KIND_TOGGLE: nxt = cur ^ lo_bit;
        default:     nxt = cur;
      endcase
    end
    return nxt;
  endfunction

endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int OFF_OUT    = 0,
  parameter int OFF_SETCLR = 4,
  parameter int OFF_TOGGLE = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind
);
  localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(OFF_OUT);
  localparam logic [ADDR_W-1:0] A_SC  = ADDR_W'(OFF_SETCLR);
  localparam logic [ADDR_W-1:0] A_TG  = ADDR_W'(OFF_TOGGLE);

  always_comb begin
    if (addr == A_OUT)      kind = KIND_OUT;
    else if (addr == A_SC)  kind = KIND_SETCLR;
    else if (addr == A_TG)  kind = KIND_TOGGLE;
    else                    kind = KIND_NONE;
  end
endmodule

// File: rtl/gpio_port_bits.sv
module gpio_port_bits
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  reg_kind_e          kind,
  input  logic [2*NPINS-1:0] wdata,
  output logic [NPINS-1:0]   pins
);
  // Named events for the assertions
  logic out_hit, sc_hit, tg_hit, any_hit;
  logic [NPINS-1:0] set_req, clr_req;

  assign out_hit = wr && (kind == KIND_OUT);
  assign sc_hit  = wr && (kind == KIND_SETCLR);
  assign tg_hit  = wr && (kind == KIND_TOGGLE);
  assign any_hit = out_hit || sc_hit || tg_hit;
  assign set_req = wdata[NPINS-1:0];
  assign clr_req = wdata[2*NPINS-1:NPINS];

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= pin_next(q, kind, wr, wdata[i], wdata[NPINS+i]);
    end
    assign pins[i] = q;
  end

  p_out_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |=> pins == $past(set_req));

  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_hit |=> (pins & $past(set_req)) == $past(set_req));

  p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sc_hit |=> (pins & $past(clr_req & ~set_req)) == '0);

  p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sc_hit |=> ((pins ^ $past(pins)) & ~$past(set_req | clr_req)) == '0);

  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tg_hit |=> pins == ($past(pins) ^ $past(set_req)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |=> $stable(pins));
endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int DATA_W = 32
) (
  input  logic              rd_en,
  input  reg_kind_e         kind,
  input  logic [NPINS-1:0]  pins,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - NPINS;

  always_comb begin
    rdata = '0;
    if (rd_en && kind == KIND_OUT) rdata = {{PAD_W{1'b0}}, pins};
  end
endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port
  import gpio_port_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int OFF_OUT    = 0,
  parameter int OFF_SETCLR = 4,
  parameter int OFF_TOGGLE = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  bus_ready,
  output logic [DATA_W/2-1:0]   pin_out
);
  localparam int NPINS = DATA_W / 2;
  localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(OFF_OUT);

  reg_kind_e kind;
  logic      wr_acc;

  assign wr_acc    = bus_sel && bus_we;
  assign bus_ready = bus_sel;

  gpio_port_decode #(
    .ADDR_W(ADDR_W), .OFF_OUT(OFF_OUT),
    .OFF_SETCLR(OFF_SETCLR), .OFF_TOGGLE(OFF_TOGGLE)
  ) u_decode (
    .addr(bus_addr),
    .kind(kind)
  );

  gpio_port_bits #(.NPINS(NPINS)) u_bits (
    .clk(clk),
    .rst_n(rst_n),
    .wr(wr_acc),
    .kind(kind),
    .wdata(bus_wdata),
    .pins(pin_out)
  );

  gpio_port_rdmux #(.NPINS(NPINS), .DATA_W(DATA_W)) u_rdmux (
    .rd_en(bus_sel),
    .kind(kind),
    .pins(pin_out),
    .rdata(bus_rdata)
  );

  p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pin_out == '0);

  p_wo_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr != A_OUT) |-> bus_rdata == '0);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == '0 && !bus_ready));

  p_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == A_OUT) |-> bus_rdata[NPINS-1:0] == pin_out);
endmodule

// File: tb/gpio_atomic_port_tb.sv
module gpio_atomic_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [15:0] pin_out;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model = '0;

  always #4 clk = ~clk;

  gpio_atomic_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .pin_out(pin_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive after the falling edge, compare, then advance the model.
  task automatic cyc(input string tag, input logic sel, input logic we,
                     input logic [3:0] addr, input logic [31:0] wd);
    logic [31:0] exp_rd;
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = addr; bus_wdata = wd;
    #1;
    exp_rd = (sel && addr == 4'h0) ? {16'h0000, model} : 32'h0;
    check({tag, " pins"}, {16'h0, pin_out}, {16'h0, model});
    check("R2 ready", {31'h0, bus_ready}, {31'h0, sel});
    check({tag, " rdata"}, bus_rdata, exp_rd);
    @(posedge clk);
    if (rst_n && sel && we) begin
      case (addr)
        4'h0: model = wd[15:0];
        4'h4: for (int b = 0; b < 16; b++) begin
                if (wd[b]) model[b] = 1'b1;
                else if (wd[b+16]) model[b] = 1'b0;
              end
        4'h8: for (int b = 0; b < 16; b++) if (wd[b]) model[b] = ~model[b];
        default: ;
      endcase
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: during reset, including a read of the output register
    cyc("R1", 1'b0, 1'b0, 4'h0, 32'h0);
    cyc("R1", 1'b1, 1'b0, 4'h0, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    cyc("R1", 1'b1, 1'b0, 4'h0, 32'h0);
    // R3: full load, upper half ignored; R9: read in write cycle shows old value
    cyc("R3", 1'b1, 1'b1, 4'h0, 32'hFFFF_A5A5);
    cyc("R9", 1'b1, 1'b0, 4'h0, 32'h0);
    cyc("R9", 1'b1, 1'b1, 4'h0, 32'h0000_0F0F);
    cyc("R3", 1'b1, 1'b0, 4'h0, 32'h0);
    // R4, R5: set and clear halves
    cyc("R4", 1'b1, 1'b1, 4'h4, 32'h0000_8030);
    cyc("R5", 1'b1, 1'b1, 4'h4, 32'h0005_0000);
    cyc("R5", 1'b1, 1'b0, 4'h0, 32'h0);
    // R6: set and clear same pin; low pin and high pin
    cyc("R6", 1'b1, 1'b1, 4'h4, 32'h0041_0041);
    cyc("R6", 1'b1, 1'b1, 4'h4, 32'h8000_8000);
    cyc("R6", 1'b1, 1'b0, 4'h0, 32'h0);
    // R7: toggle, upper half ignored
    cyc("R7", 1'b1, 1'b1, 4'h8, 32'hFFFF_00F0);
    cyc("R7", 1'b1, 1'b1, 4'h8, 32'h0000_FFFF);
    cyc("R7", 1'b1, 1'b0, 4'h0, 32'h0);
    // R8: write-only and unmapped read as zero; unmapped write no effect
    cyc("R8", 1'b1, 1'b0, 4'h4, 32'h0);
    cyc("R8", 1'b1, 1'b0, 4'h8, 32'h0);
    cyc("R8", 1'b1, 1'b1, 4'hC, 32'hFFFF_FFFF);
    cyc("R8", 1'b1, 1'b0, 4'hC, 32'h0);
    // R10: write data presented without select, or select without write
    cyc("R10", 1'b0, 1'b1, 4'h0, 32'h0000_1234);
    cyc("R10", 1'b0, 1'b1, 4'h8, 32'h0000_FFFF);
    cyc("R10", 1'b1, 1'b0, 4'h4, 32'h0000_FFFF);
    cyc("R10", 1'b1, 1'b0, 4'h0, 32'h0);
    // Mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      cyc("R9", r[0] | r[1], r[2], {r[4:3], 2'b00}, $urandom);
    end
    cyc("R9", 1'b1, 1'b0, 4'h0, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule